// File: doc/BRIEF.md
# Banked Operand Store for Parallel Modular Multipliers

This block holds the operands of a prime-field arithmetic datapath that runs several modular multipliers side by side. It contains one dual-port RAM bank per multiplier. The first port of each bank is wired straight to its own multiplier. That multiplier reads and writes only its own bank, so it needs no operand registers of its own. The second port of every bank is shared through a per-bank multiplexer. A host loads operands and collects results through it. The general modular-arithmetic unit uses it while a computation runs.

The `busy` input from the arithmetic side decides who owns the second ports. While `busy` is low, the host reaches one bank per request. While `busy` is high, the arithmetic unit drives the second port of every bank in the same cycle. During that time host requests are refused and flagged. Only the arithmetic unit can move a word that one multiplier produced into another multiplier's bank. It does this with a copy command. The command reads the source word over the source bank's second port in one cycle. It writes that word into the destination bank in the next cycle, then reports completion.

Top module: `opmem_banks`

## Requirements
- R1: A read on a multiplier port returns its own bank's word at the sampled address one clock after the address is presented.
- R2: A multiplier-port write changes only its own bank at the given address. The same address in every other bank keeps its value.
- R3: With `busy` low, an accepted host write updates the selected bank. An accepted host read raises `host_rvalid` for one cycle, one clock after the request, with the word on `host_rdata`.
- R4: A host request made while `busy` is high changes no bank and produces no `host_rvalid`. It raises `host_err` for exactly one cycle, one clock after the request.
- R5: While `busy` is high, the arithmetic unit reads or writes the second port of every bank in the same cycle. Each bank has its own address and data slice, which is slice i of `alu_addr`, `alu_wdata` and `alu_rdata`.
- R6: A copy accepted in cycle t (with `cp_start` and `busy` high) reads the source word at edge t. It writes the word to the destination bank and address at edge t+1, and `cp_done` is high for one cycle after edge t+1. Source and destination may be the same bank.
- R7: A copy request is ignored, with no write and no `cp_done`, when `busy` is low or when it arrives in the write cycle of the previous copy.
- R8: When a multiplier port and the second port of the same bank write the same address in one cycle, the second-port value is stored. `collide` bit i is high in that cycle.
- R9: A read on either port in the same cycle as a write to that address returns the word held before the write.
- R10: After reset, `host_rvalid`, `host_err` and `cp_done` are low, and `collide` is low while nothing writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| busy | input | 1 | Arithmetic side owns all second ports |
| mul_we | input | N | Per-multiplier write enable, port A |
| mul_addr | input | N*AW | Per-multiplier address, slice i for bank i |
| mul_wdata | input | N*DW | Per-multiplier write data |
| mul_rdata | output | N*DW | Per-multiplier read data, one cycle latency |
| alu_we | input | N | Arithmetic-unit write enables, one per bank |
| alu_addr | input | N*AW | Arithmetic-unit addresses, one per bank |
| alu_wdata | input | N*DW | Arithmetic-unit write data, one per bank |
| alu_rdata | output | N*DW | Second-port read data of every bank |
| cp_start | input | 1 | Copy request |
| cp_src_bank | input | BW | Copy source bank |
| cp_src_addr | input | AW | Copy source address |
| cp_dst_bank | input | BW | Copy destination bank |
| cp_dst_addr | input | AW | Copy destination address |
| cp_done | output | 1 | One-cycle pulse after the copy write |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host request is a write |
| host_bank | input | BW | Host target bank |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| host_err | output | 1 | Host request refused because busy |
| collide | output | N | Same-address write collision per bank |

## Verification
The bench issues host writes while busy is high and then reads every word back. A design that let the refused write through would show a changed word, and a missing or late `host_err` shows up directly. Copies are started in three situations: with busy low, inside the write cycle of an earlier copy, and within a single bank. A sequencer that accepted them would corrupt a destination word or emit an extra done pulse, and one that read and wrote in the wrong cycle would store stale data. Same-address writes from both ports and read-during-write cases are also driven. A design with the wrong write priority keeps the multiplier value, and a write-first RAM returns the new value too early.

// File: rtl/opmem_pkg.sv
package opmem_pkg;

  // Index width for a count of items, never below one bit.
  function automatic int unsigned idx_width(input int unsigned count);
    return (count <= 1) ? 1 : $clog2(count);
  endfunction

  // Who drives a bank's second port in a given cycle.
  typedef enum logic [2:0] {
    OWN_IDLE    = 3'd0,
    OWN_HOST    = 3'd1,
    OWN_ALU     = 3'd2,
    OWN_COPY_RD = 3'd3,
    OWN_COPY_WR = 3'd4
  } portb_owner_e;

endpackage

// File: rtl/opmem_dpram.sv
module opmem_dpram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          coll
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Both ports write one address: port B is kept.
  assign coll = a_we && b_we && (a_addr == b_addr);

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
    if (a_we && !coll) mem[a_addr] <= a_wdata;
    if (b_we)          mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/opmem_copy_seq.sv
module opmem_copy_seq #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          start,
  input  logic [BW-1:0] src_bank,
  input  logic [AW-1:0] src_addr,
  input  logic [BW-1:0] dst_bank,
  input  logic [AW-1:0] dst_addr,
  input  logic [N*DW-1:0] bank_rdata,
  output logic          accept,
  output logic          rd_claim,
  output logic [BW-1:0] rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          wr_claim,
  output logic [BW-1:0] wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  logic          wr_pend;
  logic [BW-1:0] src_bank_q;
  logic [BW-1:0] dst_bank_q;
  logic [AW-1:0] dst_addr_q;

  assign accept   = start && busy && !wr_pend;
  assign rd_claim = accept;
  assign rd_bank  = src_bank;
  assign rd_addr  = src_addr;
  assign wr_claim = wr_pend;
  assign wr_bank  = dst_bank_q;
  assign wr_addr  = dst_addr_q;
  assign wr_data  = bank_rdata[int'(src_bank_q)*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend    <= 1'b0;
      done       <= 1'b0;
      src_bank_q <= '0;
      dst_bank_q <= '0;
      dst_addr_q <= '0;
    end else begin
      wr_pend <= accept;
      done    <= wr_pend;
      if (accept) begin
        src_bank_q <= src_bank;
        dst_bank_q <= dst_bank;
        dst_addr_q <= dst_addr;
      end
    end
  end
endmodule

// File: rtl/opmem_portb_mux.sv
module opmem_portb_mux
  import opmem_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int BW  = 2,
  parameter int IDX = 0
) (
  input  logic          busy,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [BW-1:0] host_bank,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          alu_we,
  input  logic [AW-1:0] alu_addr,
  input  logic [DW-1:0] alu_wdata,
  input  logic          rd_claim,
  input  logic [BW-1:0] rd_bank,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_claim,
  input  logic [BW-1:0] wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          b_we,
  output logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_wdata
);
  localparam logic [BW-1:0] MY_BANK = BW'(IDX);

  portb_owner_e owner;

  always_comb begin
    if (wr_claim && wr_bank == MY_BANK)        owner = OWN_COPY_WR;
    else if (rd_claim && rd_bank == MY_BANK)   owner = OWN_COPY_RD;
    else if (busy)                             owner = OWN_ALU;
    else if (host_req && host_bank == MY_BANK) owner = OWN_HOST;
    else                                       owner = OWN_IDLE;
  end

  always_comb begin
    b_we    = 1'b0;
    b_addr  = alu_addr;
    b_wdata = alu_wdata;
    case (owner)
      OWN_COPY_WR: begin b_we = 1'b1;    b_addr = wr_addr;   b_wdata = wr_data;    end
      OWN_COPY_RD: begin b_we = 1'b0;    b_addr = rd_addr;                         end
      OWN_ALU:     begin b_we = alu_we;                                            end
      OWN_HOST:    begin b_we = host_we; b_addr = host_addr; b_wdata = host_wdata; end
      default:     begin b_we = 1'b0;                                              end
    endcase
  end
endmodule

// File: rtl/opmem_banks.sv
module opmem_banks
  import opmem_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int BW = idx_width(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [N-1:0]    mul_we,
  input  logic [N*AW-1:0] mul_addr,
  input  logic [N*DW-1:0] mul_wdata,
  output logic [N*DW-1:0] mul_rdata,
  input  logic [N-1:0]    alu_we,
  input  logic [N*AW-1:0] alu_addr,
  input  logic [N*DW-1:0] alu_wdata,
  output logic [N*DW-1:0] alu_rdata,
  input  logic            cp_start,
  input  logic [BW-1:0]   cp_src_bank,
  input  logic [AW-1:0]   cp_src_addr,
  input  logic [BW-1:0]   cp_dst_bank,
  input  logic [AW-1:0]   cp_dst_addr,
  output logic            cp_done,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [BW-1:0]   host_bank,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rvalid,
  output logic            host_err,
  output logic [N-1:0]    collide
);
  // Named internal events, used by the checker.
  logic            cp_accept;
  logic            cp_rd_claim;
  logic [BW-1:0]   cp_rd_bank;
  logic [AW-1:0]   cp_rd_addr;
  logic            cp_wr_phase;
  logic [BW-1:0]   cp_wr_bank;
  logic [AW-1:0]   cp_wr_addr;
  logic [DW-1:0]   cp_wr_data;
  logic [N-1:0]    b_we_all;
  logic [N*AW-1:0] b_addr_all;
  logic [N*DW-1:0] b_wdata_all;
  logic [N*DW-1:0] b_rdata_all;
  logic            host_accept;
  logic [BW-1:0]   host_bank_q;

  assign host_accept = host_req && !busy;
  assign alu_rdata   = b_rdata_all;
  assign host_rdata  = b_rdata_all[int'(host_bank_q)*DW +: DW];

  opmem_copy_seq #(.N(N), .DW(DW), .AW(AW), .BW(BW)) u_copy (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(cp_start),
    .src_bank(cp_src_bank), .src_addr(cp_src_addr),
    .dst_bank(cp_dst_bank), .dst_addr(cp_dst_addr),
    .bank_rdata(b_rdata_all), .accept(cp_accept),
    .rd_claim(cp_rd_claim), .rd_bank(cp_rd_bank), .rd_addr(cp_rd_addr),
    .wr_claim(cp_wr_phase), .wr_bank(cp_wr_bank), .wr_addr(cp_wr_addr),
    .wr_data(cp_wr_data), .done(cp_done)
  );

  for (genvar i = 0; i < N; i++) begin : g_bank
    opmem_portb_mux #(.DW(DW), .AW(AW), .BW(BW), .IDX(i)) u_mux (
      .busy(busy), .host_req(host_req), .host_we(host_we),
      .host_bank(host_bank), .host_addr(host_addr), .host_wdata(host_wdata),
      .alu_we(alu_we[i]), .alu_addr(alu_addr[i*AW +: AW]),
      .alu_wdata(alu_wdata[i*DW +: DW]),
      .rd_claim(cp_rd_claim), .rd_bank(cp_rd_bank), .rd_addr(cp_rd_addr),
      .wr_claim(cp_wr_phase), .wr_bank(cp_wr_bank), .wr_addr(cp_wr_addr),
      .wr_data(cp_wr_data),
      .b_we(b_we_all[i]), .b_addr(b_addr_all[i*AW +: AW]),
      .b_wdata(b_wdata_all[i*DW +: DW])
    );

    opmem_dpram #(.DW(DW), .AW(AW)) u_ram (
      .clk(clk),
      .a_we(mul_we[i]), .a_addr(mul_addr[i*AW +: AW]),
      .a_wdata(mul_wdata[i*DW +: DW]), .a_rdata(mul_rdata[i*DW +: DW]),
      .b_we(b_we_all[i]), .b_addr(b_addr_all[i*AW +: AW]),
      .b_wdata(b_wdata_all[i*DW +: DW]), .b_rdata(b_rdata_all[i*DW +: DW]),
      .coll(collide[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_err    <= 1'b0;
      host_bank_q <= '0;
    end else begin
      host_rvalid <= host_accept && !host_we;
      host_err    <= host_req && busy;
      if (host_accept) host_bank_q <= host_bank;
    end
  end
endmodule

// File: rtl/opmem_banks_chk.sv
module opmem_banks_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         host_req,
  input logic         host_we,
  input logic         host_rvalid,
  input logic         host_err,
  input logic         cp_start,
  input logic         cp_accept,
  input logic         cp_wr_phase,
  input logic         cp_done,
  input logic [N-1:0] collide,
  input logic [N-1:0] mul_we,
  input logic [N-1:0] b_we_all
);
  a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !busy && !host_we |=> host_rvalid);
  a_r3_no_err_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !busy |=> !host_err);
  a_r4_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && busy |=> host_err && !host_rvalid);
  a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_err && !$past(host_req) |-> 1'b0);
  a_r6_write_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cp_accept |=> cp_wr_phase);
  a_r6_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cp_wr_phase |=> cp_done);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cp_done |=> !cp_done);
  a_r7_no_copy_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start && !busy |-> !cp_accept);
  a_r7_no_copy_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    cp_wr_phase |-> !cp_accept);
  a_r8_collide_needs_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (collide & ~(mul_we & b_we_all)) == '0);
endmodule

bind opmem_banks opmem_banks_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .host_req(host_req),
  .host_we(host_we), .host_rvalid(host_rvalid), .host_err(host_err),
  .cp_start(cp_start), .cp_accept(cp_accept), .cp_wr_phase(cp_wr_phase),
  .cp_done(cp_done), .collide(collide), .mul_we(mul_we), .b_we_all(b_we_all)
);

// File: tb/test_opmem_banks.sv
module test_opmem_banks;
  localparam int N = 3, DW = 16, AW = 4, BW = 2, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, busy = 0;
  logic [N-1:0] mul_we = '0, alu_we = '0, collide;
  logic [N*AW-1:0] mul_addr = '0, alu_addr = '0;
  logic [N*DW-1:0] mul_wdata = '0, alu_wdata = '0, mul_rdata, alu_rdata;
  logic cp_start = 0, cp_done, host_req = 0, host_we = 0, host_rvalid, host_err;
  logic [BW-1:0] cp_src_bank = '0, cp_dst_bank = '0, host_bank = '0;
  logic [AW-1:0] cp_src_addr = '0, cp_dst_addr = '0, host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;

  logic [DW-1:0] ref_mem [N][DEPTH];
  logic [DW-1:0] exp_q [$];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opmem_banks #(.N(N), .DW(DW), .AW(AW)) i_opmem_banks (.*);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int b, int a);
    return DW'(b * 4096 + a * 37 + 5);
  endfunction

  // Scoreboard monitor for host reads.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check("R3 unexpected rvalid", 1, 0);
      else check("R3 host read data", host_rdata, exp_q.pop_front());
    end
  end

  task automatic host_write(int b, int a, logic [DW-1:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_bank = BW'(b); host_addr = AW'(a); host_wdata = d;
    if (!busy) ref_mem[b][a] = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic host_read(int b, int a);
    @(negedge clk);
    host_req = 1; host_we = 0; host_bank = BW'(b); host_addr = AW'(a);
    exp_q.push_back(ref_mem[b][a]);
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic copy_cmd(int sb, int sa, int db, int da);
    cp_start = 1; cp_src_bank = BW'(sb); cp_src_addr = AW'(sa);
    cp_dst_bank = BW'(db); cp_dst_addr = AW'(da);
  endtask

  task automatic mul_check_read(int b, int a, string req);
    @(negedge clk);
    mul_we = '0; mul_addr[b*AW +: AW] = AW'(a);
    @(negedge clk);
    check(req, mul_rdata[b*DW +: DW], ref_mem[b][a]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 rvalid", DW'(host_rvalid), 0);
    check("R10 err", DW'(host_err), 0);
    check("R10 done", DW'(cp_done), 0);
    check("R10 collide", DW'(collide), 0);

    // R3: host loads every bank
    for (int b = 0; b < N; b++)
      for (int a = 0; a < DEPTH; a++) host_write(b, a, pat(b, a));
    host_read(0, 3); host_read(2, 15); host_read(1, 0);

    // R1: multiplier ports read own bank, all in parallel
    busy = 1;
    @(negedge clk);
    for (int b = 0; b < N; b++) mul_addr[b*AW +: AW] = AW'(b + 4);
    @(negedge clk);
    for (int b = 0; b < N; b++) check("R1 mul read", mul_rdata[b*DW +: DW], ref_mem[b][b + 4]);

    // R2: write on bank 0 port A leaves other banks unchanged
    @(negedge clk);
    mul_we = 3'b001; mul_addr[0 +: AW] = 2; mul_wdata[0 +: DW] = 16'hBEEF;
    ref_mem[0][2] = 16'hBEEF;
    mul_check_read(0, 2, "R2 own bank written");
    mul_check_read(1, 2, "R2 bank1 untouched");
    mul_check_read(2, 2, "R2 bank2 untouched");

    // R4: host request while busy
    @(negedge clk);
    host_req = 1; host_we = 1; host_bank = 1; host_addr = 3; host_wdata = 16'hDEAD;
    @(negedge clk);
    host_req = 0; host_we = 0;
    check("R4 err pulse", DW'(host_err), 1);
    check("R4 no rvalid", DW'(host_rvalid), 0);
    @(negedge clk);
    check("R4 err one cycle", DW'(host_err), 0);
    host_req = 1; host_bank = 0; host_addr = 1;
    @(negedge clk);
    host_req = 0;
    check("R4 read refused", DW'(host_rvalid), 0);
    mul_check_read(1, 3, "R4 refused write no effect");

    // R5: arithmetic unit writes and reads all banks at once
    @(negedge clk);
    alu_we = '1;
    for (int b = 0; b < N; b++) begin
      alu_addr[b*AW +: AW] = AW'(8 + b);
      alu_wdata[b*DW +: DW] = DW'(16'hA000 + b);
      ref_mem[b][8 + b] = DW'(16'hA000 + b);
    end
    @(negedge clk);
    alu_we = '0;
    for (int b = 0; b < N; b++) alu_addr[b*AW +: AW] = AW'(8 + b);
    @(negedge clk);
    for (int b = 0; b < N; b++) check("R5 alu parallel read", alu_rdata[b*DW +: DW], ref_mem[b][8 + b]);

    // R6: cross-bank copy timing
    @(negedge clk);
    copy_cmd(0, 5, 2, 9);
    @(negedge clk);
    cp_start = 0;
    check("R6 no done in write cycle", DW'(cp_done), 0);
    @(negedge clk);
    check("R6 done pulse", DW'(cp_done), 1);
    ref_mem[2][9] = ref_mem[0][5];
    @(negedge clk);
    check("R6 done single", DW'(cp_done), 0);
    mul_check_read(2, 9, "R6 copied word");

    // R6: same-bank copy
    @(negedge clk);
    copy_cmd(1, 1, 1, 7);
    @(negedge clk);
    cp_start = 0;
    @(negedge clk);
    check("R6 same-bank done", DW'(cp_done), 1);
    ref_mem[1][7] = ref_mem[1][1];
    mul_check_read(1, 7, "R6 same-bank copied");

    // R7: copy during write phase is ignored
    @(negedge clk);
    copy_cmd(0, 6, 2, 10);
    @(negedge clk);
    copy_cmd(1, 2, 2, 3);
    @(negedge clk);
    cp_start = 0;
    check("R7 first done", DW'(cp_done), 1);
    ref_mem[2][10] = ref_mem[0][6];
    @(negedge clk);
    check("R7 no second done", DW'(cp_done), 0);
    @(negedge clk);
    check("R7 no late done", DW'(cp_done), 0);
    mul_check_read(2, 3, "R7 ignored copy no write");
    mul_check_read(2, 10, "R7 first copy written");

    // R8: same-address collision, port B wins
    @(negedge clk);
    mul_we = 3'b010; mul_addr[AW +: AW] = 4; mul_wdata[DW +: DW] = 16'h1111;
    alu_we = 3'b010; alu_addr[AW +: AW] = 4; alu_wdata[DW +: DW] = 16'h2222;
    #1;
    check("R8 collide flag", DW'(collide), 3'b010);
    ref_mem[1][4] = 16'h2222;
    @(negedge clk);
    mul_we = '0; alu_we = '0;
    #1;
    check("R8 collide clears", DW'(collide), 0);
    mul_check_read(1, 4, "R8 port B value kept");

    // R9: read-first on read during write
    @(negedge clk);
    old = ref_mem[0][6];
    mul_addr[0 +: AW] = 6;
    alu_we = 3'b001; alu_addr[0 +: AW] = 6; alu_wdata[0 +: DW] = 16'h7777;
    @(negedge clk);
    alu_we = '0;
    check("R9 old data returned", mul_rdata[0 +: DW], old);
    ref_mem[0][6] = 16'h7777;

    // R7: copy with busy low is ignored
    busy = 0;
    @(negedge clk);
    copy_cmd(0, 0, 1, 0);
    @(negedge clk);
    cp_start = 0;
    @(negedge clk);
    check("R7 idle copy no done", DW'(cp_done), 0);
    @(negedge clk);
    check("R7 idle copy no late done", DW'(cp_done), 0);

    // R3: full readback through the host
    for (int b = 0; b < N; b++)
      for (int a = 0; a < DEPTH; a++) host_read(b, a);
    repeat (3) @(negedge clk);
    check("R3 all reads returned", DW'(exp_q.size()), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule